// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the processor-facing front end of a three-channel interval timer. A host reaches it over an 8-bit data bus qualified by chip select, a write strobe, a read strobe and a two-bit address. Three of the four addresses belong to the channels, one each. The fourth holds a shared control register. Every byte written there is a setup word that names one channel and gives that channel a counting mode, a BCD/binary choice and a byte access format.

Count values written by the host are assembled from one or two bytes, according to the channel's access format. Each finished value goes to the counter logic with a one-cycle load strobe. The counters' live 16-bit values come back on a separate input. A read at a channel address returns one byte of that value, in the order the format gives. The counters themselves sit outside this block.

Top module: `timer_host_if`

## Requirements
- R1: After reset every channel is unprogrammed. All mode, BCD, setup-strobe, load and value outputs are zero, and the read data register is zero.
- R2: A write with chip select high at address 3 is a setup word. Bit 0 is the BCD flag (1 = BCD). Bits 3..1 are the mode. Bits 5..4 are the access format: 01 low byte only, 10 high byte only, 11 low byte then high byte. Bits 7..6 name channel 0, 1 or 2. The new mode and BCD flag show on that channel's outputs on the first clock after the write.
- R3: A mode field of 6 or 7 is stored and output as 2 or 3 respectively.
- R4: A setup word whose channel field is 11, or whose format field is 00, changes no setting and gives no strobe. A valid setup word pulses that channel's setup strobe for exactly one cycle, on the first clock after the write.
- R5: In low-byte-only format, each write to the channel loads the value {00h, byte}. The load strobe pulses for one cycle after the write, and the value output holds until the next load.
- R6: In high-byte-only format, each write loads {byte, 00h} with the same timing as R5.
- R7: In low-then-high format, the first write only stores the low byte. The second write loads {second byte, first byte}. A setup word to that channel restarts the sequence at the low byte.
- R8: Count writes to a channel that has not yet received a valid setup word give no load and change no value.
- R9: A read with chip select high updates the read data register on that clock, and the register then holds. Depending on the format, a channel address returns the live count's low byte, its high byte, or the low byte and high byte in turn (restarted by a setup word). Address 3 returns 00h, and so does an unprogrammed channel.
- R10: Addresses 0, 1 and 2 select channels 0, 1 and 2. With chip select low, neither strobe has any effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Chip select, active high |
| bus_wr | input | 1 | Write strobe; each qualified cycle is one write |
| bus_rd | input | 1 | Read strobe; each qualified cycle is one read |
| bus_addr | input | 2 | Channel 0..2 or setup register (3) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ch_cw_stb | output | 3 | Per-channel setup-word strobe |
| ch_mode | output | 9 | Mode per channel, 3 bits each, channel 0 lowest |
| ch_bcd | output | 3 | BCD flag per channel |
| ch_load | output | 3 | Per-channel count-load strobe |
| ch_value | output | 48 | Count value per channel, 16 bits each |
| ch_count_in | input | 48 | Live count per channel, 16 bits each |

## Verification
Every result of this block is due exactly one clock after the cycle in which the bus access was sampled. This holds for the setup strobe, the mode and BCD outputs, the load strobe with its value, and the read byte. A first write in the two-byte format must give no load at all. The bench drives one access per clock at the falling edge. A behavioural model predicts the outputs from that access and from the live count present at the same moment. At the next falling edge the bench compares every output with the prediction, so a result that comes one cycle early or late fails at once. Explicit checks also cover mode folding, ignored setup words, unprogrammed channels, sequence restart and reads of the setup address.

// File: rtl/tmr_host_pkg.sv
package tmr_host_pkg;
  localparam int NUM_CH = 3;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 2'd3;

  typedef enum logic [1:0] {
    FMT_NONE = 2'b00,
    FMT_LSB  = 2'b01,
    FMT_MSB  = 2'b10,
    FMT_BOTH = 2'b11
  } acc_fmt_e;

  typedef struct packed {
    logic [2:0] mode;
    logic       bcd;
    acc_fmt_e   fmt;
  } ch_cfg_t;

  // modes 6 and 7 alias onto 2 and 3
  function automatic logic [2:0] fold_mode(input logic [2:0] m);
    return (m[2] && m[1]) ? {1'b0, m[1:0]} : m;
  endfunction

  function automatic ch_cfg_t cw_to_cfg(input logic [7:0] cw);
    ch_cfg_t c;
    c.mode = fold_mode(cw[3:1]);
    c.bcd  = cw[0];
    c.fmt  = acc_fmt_e'(cw[5:4]);
    return c;
  endfunction

  function automatic logic cw_usable(input logic [7:0] cw);
    return (cw[7:6] != 2'b11) && (cw[5:4] != 2'b00);
  endfunction
endpackage

// File: rtl/tmr_cw_decode.sv
module tmr_cw_decode
  import tmr_host_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              cw_wr,
  input  logic [DATA_W-1:0] cw_data,
  output logic [NUM_CH-1:0] cw_hit,
  output ch_cfg_t           cw_cfg
);
  logic [7:0] cw_byte;
  logic       usable;

  assign cw_byte = cw_data[7:0];
  assign usable  = cw_usable(cw_byte);
  assign cw_cfg  = cw_to_cfg(cw_byte);

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      cw_hit[i] = cw_wr && usable && (cw_byte[7:6] == i[1:0]);
    end
  end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_host_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cw_hit,
  input  ch_cfg_t           cw_cfg,
  input  logic              wr_hit,
  input  logic              rd_hit,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt_in,
  output ch_cfg_t           cfg,
  output logic              cw_stb,
  output logic              load,
  output logic [CNT_W-1:0]  value,
  output logic [DATA_W-1:0] rbyte,
  output logic              wr_second
);
  ch_cfg_t           cfg_q;
  logic              wr_tog_q;
  logic              rd_tog_q;
  logic [DATA_W-1:0] lo_q;
  logic [CNT_W-1:0]  value_q;
  logic              load_q;
  logic              cw_stb_q;

  function automatic logic [CNT_W-1:0] join_bytes(input logic [DATA_W-1:0] hi,
                                                  input logic [DATA_W-1:0] lo);
    return {hi, lo};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      wr_tog_q <= 1'b0;
      rd_tog_q <= 1'b0;
      lo_q     <= '0;
      value_q  <= '0;
      load_q   <= 1'b0;
      cw_stb_q <= 1'b0;
    end else begin
      load_q   <= 1'b0;
      cw_stb_q <= cw_hit;
      if (cw_hit) begin
        cfg_q    <= cw_cfg;
        wr_tog_q <= 1'b0;
        rd_tog_q <= 1'b0;
      end else begin
        if (wr_hit) begin
          case (cfg_q.fmt)
            FMT_LSB: begin
              value_q <= join_bytes('0, wdata);
              load_q  <= 1'b1;
            end
            FMT_MSB: begin
              value_q <= join_bytes(wdata, '0);
              load_q  <= 1'b1;
            end
            FMT_BOTH: begin
              if (!wr_tog_q) begin
                lo_q     <= wdata;
                wr_tog_q <= 1'b1;
              end else begin
                value_q  <= join_bytes(wdata, lo_q);
                load_q   <= 1'b1;
                wr_tog_q <= 1'b0;
              end
            end
            default: ;
          endcase
        end
        if (rd_hit && (cfg_q.fmt == FMT_BOTH)) rd_tog_q <= ~rd_tog_q;
      end
    end
  end

  always_comb begin
    case (cfg_q.fmt)
      FMT_LSB:  rbyte = cnt_in[DATA_W-1:0];
      FMT_MSB:  rbyte = cnt_in[CNT_W-1:DATA_W];
      FMT_BOTH: rbyte = rd_tog_q ? cnt_in[CNT_W-1:DATA_W] : cnt_in[DATA_W-1:0];
      default:  rbyte = '0;
    endcase
  end

  assign cfg       = cfg_q;
  assign cw_stb    = cw_stb_q;
  assign load      = load_q;
  assign value     = value_q;
  assign wr_second = wr_tog_q;
endmodule

// File: rtl/tmr_rd_port.sv
module tmr_rd_port
  import tmr_host_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_ev,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NUM_CH*DATA_W-1:0] rbytes,
  output logic [DATA_W-1:0]        rdata
);
  logic [DATA_W-1:0] sel_byte;

  always_comb begin
    sel_byte = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == i[ADDR_W-1:0]) sel_byte = rbytes[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_ev) rdata <= sel_byte;
  end
endmodule

// File: rtl/timer_host_if.sv
module timer_host_if
  import tmr_host_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_cs,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic [NUM_CH-1:0]        ch_cw_stb,
  output logic [NUM_CH*3-1:0]      ch_mode,
  output logic [NUM_CH-1:0]        ch_bcd,
  output logic [NUM_CH-1:0]        ch_load,
  output logic [NUM_CH*CNT_W-1:0]  ch_value,
  input  logic [NUM_CH*CNT_W-1:0]  ch_count_in
);
  // named internal events, observed by the bound checker
  logic                     wr_ev;
  logic                     rd_ev;
  logic                     cw_wr;
  logic [NUM_CH-1:0]        cw_hit;
  logic [NUM_CH-1:0]        wr_hit;
  logic [NUM_CH-1:0]        rd_hit;
  logic [NUM_CH-1:0]        wr_tog;
  logic [2*NUM_CH-1:0]      ch_fmt;
  logic [NUM_CH*DATA_W-1:0] rbytes;
  ch_cfg_t                  cw_cfg;

  assign wr_ev = bus_cs && bus_wr;
  assign rd_ev = bus_cs && bus_rd;
  assign cw_wr = wr_ev && (bus_addr == CTRL_ADDR);

  tmr_cw_decode #(.DATA_W(DATA_W)) u_dec (
    .cw_wr  (cw_wr),
    .cw_data(bus_wdata),
    .cw_hit (cw_hit),
    .cw_cfg (cw_cfg)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    ch_cfg_t cfg;

    assign wr_hit[g] = wr_ev && (bus_addr == g[ADDR_W-1:0]);
    assign rd_hit[g] = rd_ev && (bus_addr == g[ADDR_W-1:0]);

    tmr_chan_regs #(.DATA_W(DATA_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .cw_hit   (cw_hit[g]),
      .cw_cfg   (cw_cfg),
      .wr_hit   (wr_hit[g]),
      .rd_hit   (rd_hit[g]),
      .wdata    (bus_wdata),
      .cnt_in   (ch_count_in[g*CNT_W +: CNT_W]),
      .cfg      (cfg),
      .cw_stb   (ch_cw_stb[g]),
      .load     (ch_load[g]),
      .value    (ch_value[g*CNT_W +: CNT_W]),
      .rbyte    (rbytes[g*DATA_W +: DATA_W]),
      .wr_second(wr_tog[g])
    );

    assign ch_mode[g*3 +: 3] = cfg.mode;
    assign ch_bcd[g]         = cfg.bcd;
    assign ch_fmt[g*2 +: 2]  = cfg.fmt;
  end

  tmr_rd_port #(.DATA_W(DATA_W)) u_rd (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_ev (rd_ev),
    .addr  (bus_addr),
    .rbytes(rbytes),
    .rdata (bus_rdata)
  );
endmodule

// File: rtl/timer_host_if_chk.sv
module timer_host_if_chk
  import tmr_host_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_cs,
  input logic                    bus_wr,
  input logic                    bus_rd,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic [DATA_W-1:0]       bus_rdata,
  input logic [NUM_CH-1:0]       ch_cw_stb,
  input logic [NUM_CH-1:0]       ch_load,
  input logic [NUM_CH*CNT_W-1:0] ch_value,
  input logic [NUM_CH-1:0]       cw_hit,
  input logic [NUM_CH-1:0]       wr_tog,
  input logic [2*NUM_CH-1:0]     ch_fmt
);
  AST_CW_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cw_hit)); // R2

  AST_CTRL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs && bus_rd && bus_addr == CTRL_ADDR) |=> (bus_rdata == '0)); // R9

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_cs && bus_rd) |=> $stable(bus_rdata)); // R9

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    AST_STB_FROM_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ch_cw_stb[i] |-> $past(bus_cs && bus_wr && bus_addr == CTRL_ADDR)); // R4

    AST_LOAD_FROM_OWN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ch_load[i] |-> $past(bus_cs && bus_wr && bus_addr == i[ADDR_W-1:0])); // R10

    AST_LOAD_NEEDS_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      ch_load[i] |-> ($past(ch_fmt[2*i +: 2]) != 2'b00)); // R8

    AST_LSB_ONLY_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_load[i] && $past(ch_fmt[2*i +: 2]) == 2'b01)
        |-> (ch_value[i*CNT_W + DATA_W +: DATA_W] == '0)); // R5

    AST_MSB_ONLY_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_load[i] && $past(ch_fmt[2*i +: 2]) == 2'b10)
        |-> (ch_value[i*CNT_W +: DATA_W] == '0)); // R6

    AST_PAIR_ON_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_load[i] && $past(ch_fmt[2*i +: 2]) == 2'b11) |-> $past(wr_tog[i])); // R7
  end
endmodule

bind timer_host_if timer_host_if_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_cs   (bus_cs),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata),
  .ch_cw_stb(ch_cw_stb),
  .ch_load  (ch_load),
  .ch_value (ch_value),
  .cw_hit   (cw_hit),
  .wr_tog   (wr_tog),
  .ch_fmt   (ch_fmt)
);

// File: tb/tb_timer_host_if.sv
`timescale 1ns/1ps
module tb_timer_host_if;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_cs, bus_wr, bus_rd;
  logic [1:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [2:0]  ch_cw_stb, ch_bcd, ch_load;
  logic [8:0]  ch_mode;
  logic [47:0] ch_value, ch_count_in;
  logic [15:0] cnt [3];

  int nchk = 0, nerr = 0, ncyc = 0;
  bit done = 0;

  // behavioural model state
  int m_fmt [3], m_mode [3], m_bcd [3], m_wt [3], m_rt [3], m_lo [3], m_val [3];
  int e_load [3], e_cw [3];
  int e_rdata;

  always #4 clk = ~clk;
  assign ch_count_in = {cnt[2], cnt[1], cnt[0]};

  timer_host_if dut (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ch_cw_stb(ch_cw_stb), .ch_mode(ch_mode), .ch_bcd(ch_bcd), .ch_load(ch_load),
    .ch_value(ch_value), .ch_count_in(ch_count_in)
  );

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 50000 && !done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog: actual %0d expected <50000 cycles", ncyc);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    for (int i = 0; i < 3; i++) begin
      chk("R2", "mode", int'(ch_mode[3*i +: 3]), m_mode[i]);
      chk("R2", "bcd", int'(ch_bcd[i]), m_bcd[i]);
      chk("R4", "setup strobe", int'(ch_cw_stb[i]), e_cw[i]);
      chk("R8", "load strobe", int'(ch_load[i]), e_load[i]);
      chk("R5", "value", int'(ch_value[16*i +: 16]), m_val[i]);
    end
    chk("R9", "read data", int'(bus_rdata), e_rdata);
  endtask

  // one bus cycle: drive, predict, then compare one clock later
  task automatic cyc(input logic cs, input logic wr, input logic rd,
                     input logic [1:0] a, input logic [7:0] d);
    int c, f, md;
    bus_cs = cs; bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    for (int i = 0; i < 3; i++) begin e_load[i] = 0; e_cw[i] = 0; end
    c = int'(a);
    if (cs && rd) begin
      if (c == 3) e_rdata = 0;
      else if (m_fmt[c] == 1) e_rdata = int'(cnt[c][7:0]);
      else if (m_fmt[c] == 2) e_rdata = int'(cnt[c][15:8]);
      else if (m_fmt[c] == 3) begin
        e_rdata = m_rt[c] ? int'(cnt[c][15:8]) : int'(cnt[c][7:0]);
        m_rt[c] = 1 - m_rt[c];
      end else e_rdata = 0;
    end
    if (cs && wr) begin
      if (c == 3) begin
        f  = int'(d[5:4]);
        md = int'(d[3:1]);
        c  = int'(d[7:6]);
        if (c != 3 && f != 0) begin
          m_fmt[c] = f;
          m_mode[c] = (md > 5) ? md - 4 : md;
          m_bcd[c] = int'(d[0]);
          m_wt[c] = 0; m_rt[c] = 0;
          e_cw[c] = 1;
        end
      end else if (m_fmt[c] == 1) begin
        m_val[c] = int'(d); e_load[c] = 1;
      end else if (m_fmt[c] == 2) begin
        m_val[c] = int'(d) * 256; e_load[c] = 1;
      end else if (m_fmt[c] == 3) begin
        if (m_wt[c] == 0) begin m_lo[c] = int'(d); m_wt[c] = 1; end
        else begin m_val[c] = int'(d) * 256 + m_lo[c]; m_wt[c] = 0; e_load[c] = 1; end
      end
    end
    @(negedge clk);
    compare();
  endtask

  task automatic wr_b(input logic [1:0] a, input logic [7:0] d); cyc(1, 1, 0, a, d); endtask
  task automatic rd_b(input logic [1:0] a); cyc(1, 0, 1, a, 8'h00); endtask
  task automatic idle(); cyc(0, 0, 0, 2'd0, 8'h00); endtask

  initial begin
    rst_n = 0; bus_cs = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    cnt[0] = 16'hBEEF; cnt[1] = 16'h1234; cnt[2] = 16'hCAFE;
    for (int i = 0; i < 3; i++) begin
      m_fmt[i] = 0; m_mode[i] = 0; m_bcd[i] = 0; m_wt[i] = 0; m_rt[i] = 0;
      m_lo[i] = 0; m_val[i] = 0; e_load[i] = 0; e_cw[i] = 0;
    end
    e_rdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "load after reset", int'(ch_load), 0);
    chk("R1", "value after reset", int'(ch_value != 0), 0);
    chk("R1", "mode after reset", int'(ch_mode), 0);
    chk("R1", "rdata after reset", int'(bus_rdata), 0);
    chk("R1", "strobe after reset", int'(ch_cw_stb), 0);

    // R8 unprogrammed channel, R10 chip select low
    wr_b(2'd2, 8'h55);
    chk("R8", "no load on unprogrammed", int'(ch_load[2]), 0);
    rd_b(2'd2);
    chk("R9", "unprogrammed read", int'(bus_rdata), 0);
    cyc(0, 1, 0, 2'd3, 8'h36);
    chk("R10", "setup ignored without cs", int'(ch_cw_stb), 0);

    // R2 decode
    wr_b(2'd3, 8'h36);
    chk("R2", "ch0 mode 3", int'(ch_mode[2:0]), 3);
    wr_b(2'd3, 8'h54);
    chk("R2", "ch1 mode 2", int'(ch_mode[5:3]), 2);
    // R3 folding
    wr_b(2'd3, 8'hBE);
    chk("R3", "mode 7 folds to 3", int'(ch_mode[8:6]), 3);
    wr_b(2'd3, 8'h9D);
    chk("R3", "mode 6 folds to 2", int'(ch_mode[8:6]), 2);
    chk("R2", "bcd flag", int'(ch_bcd[2]), 1);
    // R4 ignored words
    wr_b(2'd3, 8'hF6);
    wr_b(2'd3, 8'h0C);
    chk("R4", "ch0 mode kept", int'(ch_mode[2:0]), 3);
    chk("R4", "no strobe", int'(ch_cw_stb), 0);

    // R5 low only
    wr_b(2'd1, 8'h12);
    chk("R5", "lsb load", int'(ch_value[31:16]), 16'h0012);
    cyc(0, 1, 0, 2'd1, 8'h77);
    chk("R10", "write ignored without cs", int'(ch_value[31:16]), 16'h0012);
    // R6 high only
    wr_b(2'd3, 8'h64);
    wr_b(2'd1, 8'h34);
    chk("R6", "msb load", int'(ch_value[31:16]), 16'h3400);
    // R7 pair
    wr_b(2'd0, 8'h78);
    chk("R7", "no load on first byte", int'(ch_load[0]), 0);
    wr_b(2'd0, 8'h9A);
    chk("R7", "pair load", int'(ch_value[15:0]), 16'h9A78);
    wr_b(2'd0, 8'h11);
    wr_b(2'd3, 8'h36);
    wr_b(2'd0, 8'h22);
    wr_b(2'd0, 8'h33);
    chk("R7", "restart after setup", int'(ch_value[15:0]), 16'h3322);

    // R9 reads
    rd_b(2'd1);
    chk("R9", "msb read", int'(bus_rdata), 8'h12);
    rd_b(2'd2);
    chk("R9", "lsb read", int'(bus_rdata), 8'hFE);
    rd_b(2'd0);
    chk("R9", "pair read low", int'(bus_rdata), 8'hEF);
    idle();
    chk("R9", "read data holds", int'(bus_rdata), 8'hEF);
    rd_b(2'd0);
    chk("R9", "pair read high", int'(bus_rdata), 8'hBE);
    rd_b(2'd3);
    chk("R9", "setup address reads zero", int'(bus_rdata), 0);

    // mixed traffic against the model
    for (int n = 0; n < 600; n++) begin
      int op;
      logic [1:0] a;
      op = int'($urandom_range(0, 9));
      a = 2'($urandom_range(0, 3));
      if (op == 0) cnt[a % 3] = 16'($urandom);
      if (op < 2) idle();
      else if (op < 4) wr_b(2'd3, 8'($urandom));
      else if (op < 7) wr_b(a, 8'($urandom));
      else if (op < 9) rd_b(a);
      else cyc(1'($urandom), 1'($urandom), 1'($urandom), a, 8'($urandom));
    end
    idle();

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule